// File: doc/BRIEF.md
# I2C Auto-Mode Transfer Sequencer

This block is the controller-side engine of an I2C master that carries out a whole message from a single launch word. Software writes the byte count, the direction, a stop-after-transfer flag and a run bit in one word, together with a 7-bit target address. The engine then generates the start condition, sends the address byte, moves the data bytes, checks every acknowledge and finishes with either a stop or a held bus. Transmit bytes are pulled from a byte input with a one-cycle take pulse. Received bytes are pushed out with a one-cycle valid pulse.

The bus is driven through two open-drain enables, where 1 means pull the line low. A separate timing module supplies a strobe at four times the bit rate, so each bit is divided into four quarter-bit phases. Completion and error conditions are reported in a 32-bit status word.

When the stop flag of a launch is clear, SCL is held low after the last byte. The next launch then opens with a repeated start, which lets a write of a register index chain into a read without freeing the bus. Addressing is limited to 7 bits; 10-bit addressing, high-speed master codes and target-side operation are not part of the block.

Top module: `i2c_auto_seq`

## Requirements
- R1: After reset both open-drain enables are 0 and every bit of the status word is 0.
- R2: A launch is accepted only when launchWr is high and bit 31 (run) of launchWord is 1. Bits [CNT_W-1:0] of launchWord give the byte count, bit 16 the direction (1 = read) and bit 17 stop-after-transfer. The target address is taken from addrWord bits [16:10]. The address byte on the bus is {address, direction}, and a count of 0 sends the address byte only.
- R3: On a write, each data byte goes out MSB first after the address byte, and each is taken from txData in the cycle txTake is high.
- R4: On a read, each received byte appears on rxData with a one-cycle rxValid pulse. The master acknowledges (drives SDA low) every byte except the last, which it leaves unacknowledged.
- R5: With stop-after-transfer set, a successful transfer ends with a stop condition. Busy (status bit 17) stays 1 until the stop is complete and then returns to 0. While busy is 0, both lines are released.
- R6: With stop-after-transfer clear, SCL is held low and busy stays 1 after the last byte, with no stop. The next accepted launch begins with a repeated start.
- R7: Done (status bit 0) is set when all bytes of a transfer complete without error, stays set, and clears in the cycle after a statusRd pulse.
- R8: A NACK to the address byte sets no-device (status bit 3), starts a stop in the same cycle and does not set done.
- R9: A NACK to a write data byte sets no-ack (status bit 2), starts a stop in the same cycle, and no further byte is taken.
- R10: If SDA is sampled low while the master is releasing it during an address or write data bit, abort (status bit 1) is set, both lines are released in the same cycle, busy drops, and no stop is sent.
- R11: A launch that arrives while a transfer is running (busy set and the bus not held) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit timing strobe, one cycle wide |
| launchWr | input | 1 | Launch word write strobe |
| launchWord | input | 32 | Count, direction, stop and run fields |
| addrWord | input | 32 | Target address in bits [16:10] |
| statusRd | input | 1 | Status read strobe; clears done |
| status | output | 32 | Done, abort, no-ack, no-device, busy |
| txData | input | 8 | Next byte to transmit |
| txTake | output | 1 | txData consumed this cycle |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData valid this cycle |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach from the ports is arbitration loss. It needs a second bus driver pulling SDA low at the very quarter-bit sample point where the engine releases SDA for a 1 bit. The bench reaches it with a target address whose MSB is 1 and an extra bus pull-down that it asserts before the launch, so the first address bit collides. A second hard case is the repeated start after a held bus. A write without stop is followed by a read, and the bench's target model counts start conditions seen while SCL is high to confirm that a second start occurs with no stop between them.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int LW_DIR  = 16;
  localparam int LW_STOP = 17;
  localparam int LW_RUN  = 31;
  localparam int AW_LSB  = 10;
  localparam int AW_MSB  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_STOP, ST_HOLD
  } seqState_e;

  typedef struct packed {
    logic phRun;
    logic phClr;
    logic bitClr;
    logic loadAddr;
    logic loadTx;
    logic loadCnt;
    logic decCnt;
  } dpCtl_t;
endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpCtl_t           ctl,
  input  logic [7:0]       addrByte,
  input  logic [7:0]       txData,
  input  logic [CNT_W-1:0] cntInit,
  input  logic             sdaIn,
  output logic [1:0]       phase,
  output logic [3:0]       bitIdx,
  output logic             shMsb,
  output logic             sampBit,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       rxByte
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  logic [7:0] shReg;
  logic       phEnd;
  logic       samp;

  assign phEnd  = ctl.phRun && tick && (phase == 2'd3);
  assign samp   = ctl.phRun && tick && (phase == 2'd2);
  assign shMsb  = shReg[7];
  assign rxByte = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      bitIdx  <= '0;
      shReg   <= '0;
      sampBit <= 1'b1;
      cnt     <= '0;
    end else begin
      if (ctl.phClr) phase <= '0;
      else if (ctl.phRun && tick) phase <= phase + 2'd1;

      if (ctl.bitClr) bitIdx <= '0;
      else if (phEnd) bitIdx <= (bitIdx == ACK_BIT) ? 4'd0 : bitIdx + 4'd1;

      if (samp) sampBit <= sdaIn;

      if (ctl.loadAddr) shReg <= addrByte;
      else if (ctl.loadTx) shReg <= txData;
      else if (phEnd && !ctl.bitClr && bitIdx < ACK_BIT) shReg <= {shReg[6:0], sampBit};

      if (ctl.loadCnt) cnt <= cntInit;
      else if (ctl.decCnt) cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/seq_ctl.sv
module seq_ctl
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             launchWr,
  input  logic             runBit,
  input  logic             dirBit,
  input  logic             stopBit,
  input  logic             statusRd,
  input  logic             sdaIn,
  input  logic [1:0]       phase,
  input  logic [3:0]       bitIdx,
  input  logic             shMsb,
  input  logic             sampBit,
  input  logic [CNT_W-1:0] cnt,
  output dpCtl_t           ctl,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             txTake,
  output logic             rxValid,
  output logic             doneSet,
  output logic [31:0]      status
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  seqState_e state;
  logic dirRd, stopAfter, fromHold;
  logic doneF, abortF, noAckF, noDevF;

  logic inByte, phRun, phEnd, samp, byteEnd, launchOk;
  logic releasing, arbLost, lastByte, addrLast, dataLast, nackAddr, nackData;

  assign inByte    = (state == ST_ADDR) || (state == ST_DATA);
  assign phRun     = inByte || (state == ST_START) || (state == ST_STOP);
  assign phEnd     = phRun && tick && (phase == 2'd3);
  assign samp      = phRun && tick && (phase == 2'd2);
  assign byteEnd   = inByte && phEnd && (bitIdx == ACK_BIT);
  assign launchOk  = launchWr && runBit && ((state == ST_IDLE) || (state == ST_HOLD));
  assign lastByte  = (cnt == CNT_W'(1));
  assign releasing = ((state == ST_ADDR) || (state == ST_DATA && !dirRd)) &&
                     (bitIdx < ACK_BIT) && shMsb;
  assign arbLost   = samp && releasing && !sdaIn;
  assign nackAddr  = byteEnd && (state == ST_ADDR) && sampBit;
  assign nackData  = byteEnd && (state == ST_DATA) && !dirRd && sampBit;
  assign addrLast  = byteEnd && (state == ST_ADDR) && !sampBit && (cnt == '0);
  assign dataLast  = byteEnd && (state == ST_DATA) && !nackData && lastByte;
  assign doneSet   = addrLast || dataLast;

  always_comb begin
    ctl          = '0;
    ctl.phRun    = phRun;
    ctl.phClr    = launchOk;
    ctl.bitClr   = !inByte;
    ctl.loadAddr = launchOk;
    ctl.loadCnt  = launchOk;
    ctl.decCnt   = byteEnd && (state == ST_DATA);
    ctl.loadTx   = byteEnd && !dirRd &&
                   (((state == ST_ADDR) && !nackAddr && (cnt != '0)) ||
                    ((state == ST_DATA) && !nackData && !lastByte));
  end

  assign txTake  = ctl.loadTx;
  assign rxValid = byteEnd && (state == ST_DATA) && dirRd;

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    unique case (state)
      ST_HOLD:  sclOe = 1'b1;
      ST_START: begin
        sclOe = ((phase == 2'd0) && fromHold) || (phase == 2'd3);
        sdaOe = phase[1];
      end
      ST_ADDR, ST_DATA: begin
        sclOe = (phase == 2'd0) || (phase == 2'd3);
        if (bitIdx == ACK_BIT) sdaOe = (state == ST_DATA) && dirRd && !lastByte;
        else sdaOe = ((state == ST_ADDR) || !dirRd) && !shMsb;
      end
      ST_STOP: begin
        sclOe = (phase == 2'd0);
        sdaOe = !phase[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dirRd     <= 1'b0;
      stopAfter <= 1'b0;
      fromHold  <= 1'b0;
      doneF     <= 1'b0;
      abortF    <= 1'b0;
      noAckF    <= 1'b0;
      noDevF    <= 1'b0;
    end else begin
      if (doneSet) doneF <= 1'b1;
      else if (statusRd) doneF <= 1'b0;

      if (launchOk) begin
        state     <= ST_START;
        dirRd     <= dirBit;
        stopAfter <= stopBit;
        fromHold  <= (state == ST_HOLD);
        abortF    <= 1'b0;
        noAckF    <= 1'b0;
        noDevF    <= 1'b0;
      end else if (arbLost) begin
        state  <= ST_IDLE;
        abortF <= 1'b1;
      end else if (nackAddr) begin
        state  <= ST_STOP;
        noDevF <= 1'b1;
      end else if (nackData) begin
        state  <= ST_STOP;
        noAckF <= 1'b1;
      end else if (doneSet) begin
        state <= stopAfter ? ST_STOP : ST_HOLD;
      end else if (phEnd) begin
        unique case (state)
          ST_START: state <= ST_ADDR;
          ST_ADDR:  if (bitIdx == ACK_BIT) state <= ST_DATA;
          ST_STOP:  state <= ST_IDLE;
          default:  ;
        endcase
      end
    end
  end

  assign status = {14'd0, (state != ST_IDLE), 1'b0, 11'd0, 1'b0,
                   noDevF, noAckF, abortF, doneF};
endmodule

// File: rtl/i2c_auto_seq.sv
module i2c_auto_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        launchWr,
  input  logic [31:0] launchWord,
  input  logic [31:0] addrWord,
  input  logic        statusRd,
  output logic [31:0] status,
  input  logic [7:0]  txData,
  output logic        txTake,
  output logic [7:0]  rxData,
  output logic        rxValid,
  output logic        sclOe,
  output logic        sdaOe,
  input  logic        sdaIn
);
  dpCtl_t           ctlStb;
  logic [1:0]       phase;
  logic [3:0]       bitIdx;
  logic             shMsb, sampBit, doneSet;
  logic [CNT_W-1:0] cnt;
  logic             unusedBits;

  assign unusedBits = ^{launchWord[LW_RUN-1:LW_STOP+1], launchWord[LW_DIR-1:CNT_W],
                        addrWord[31:AW_MSB+1], addrWord[AW_LSB-1:0]};

  seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctlStb),
    .addrByte({addrWord[AW_MSB:AW_LSB], launchWord[LW_DIR]}),
    .txData(txData), .cntInit(launchWord[CNT_W-1:0]), .sdaIn(sdaIn),
    .phase(phase), .bitIdx(bitIdx), .shMsb(shMsb), .sampBit(sampBit),
    .cnt(cnt), .rxByte(rxData)
  );

  seq_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .launchWr(launchWr),
    .runBit(launchWord[LW_RUN]), .dirBit(launchWord[LW_DIR]),
    .stopBit(launchWord[LW_STOP]), .statusRd(statusRd), .sdaIn(sdaIn),
    .phase(phase), .bitIdx(bitIdx), .shMsb(shMsb), .sampBit(sampBit),
    .cnt(cnt), .ctl(ctlStb), .sclOe(sclOe), .sdaOe(sdaOe),
    .txTake(txTake), .rxValid(rxValid), .doneSet(doneSet), .status(status)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sclOe,
  input logic        sdaOe,
  input logic [31:0] status,
  input logic        statusRd,
  input logic        doneSet
);
  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !status[17] |-> (!sclOe && !sdaOe));

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> (!sclOe && !sdaOe && !status[17]));

  // R8
  nodev_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> (sclOe && sdaOe && status[17] && !status[0]));

  // R9
  noack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> (sclOe && sdaOe && status[17]));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !doneSet) |=> !status[0]);
endmodule

bind i2c_auto_seq seq_chk u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe),
  .status(status), .statusRd(statusRd), .doneSet(doneSet)
);

// File: tb/test_i2c_auto_seq.sv
module test_i2c_auto_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] DEV_ADDR = 7'h5A;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic launchWr = 1'b0, statusRd = 1'b0;
  logic [31:0] launchWord = '0, addrWord = '0, status;
  logic [7:0] txData, rxData;
  logic txTake, rxValid, sclOe, sdaOe;
  logic slvLow = 1'b0, otherLow = 1'b0;
  wire sclW = !sclOe;
  wire sdaW = !(sdaOe || slvLow || otherLow);

  int checks = 0, errors = 0;
  logic [1:0] tdiv = '0;

  // target model state
  int bitCnt = 0, startCnt = 0, stopCnt = 0, wrCnt = 0, mAckCnt = 0, rdIdx = 0, nackAt = -1;
  logic addrPh = 1'b0, active = 1'b0, isRead = 1'b0, ackSeen = 1'b0;
  logic [7:0] shIn = '0, lastAddr = '0, rdByte = '0;
  logic [7:0] wrLog [0:7];
  logic mAck [0:7];
  logic [7:0] rdData [0:7];
  logic [7:0] txBuf [0:7];
  logic [7:0] rxLog [0:7];
  int txIdx = 0, rxCnt = 0;

  assign txData = txBuf[txIdx[2:0]];

  i2c_auto_seq i_i2c_auto_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .launchWr(launchWr),
    .launchWord(launchWord), .addrWord(addrWord), .statusRd(statusRd),
    .status(status), .txData(txData), .txTake(txTake), .rxData(rxData),
    .rxValid(rxValid), .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sdaW)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  always @(posedge clk) begin
    if (txTake) txIdx <= txIdx + 1;
    if (rxValid) begin
      rxLog[rxCnt[2:0]] <= rxData;
      rxCnt <= rxCnt + 1;
    end
  end

  always @(negedge sdaW) if (sclW === 1'b1) begin
    startCnt++; bitCnt = 0; addrPh = 1'b1; slvLow = 1'b0;
  end
  always @(posedge sdaW) if (sclW === 1'b1 && rstN) begin
    stopCnt++; addrPh = 1'b0; active = 1'b0;
  end
  always @(posedge sclW) begin
    if (bitCnt < 8) begin shIn = {shIn[6:0], sdaW}; bitCnt++; end
    else if (bitCnt == 8) begin ackSeen = sdaW; bitCnt = 9; end
  end
  always @(negedge sclW) begin
    if (bitCnt == 8) begin
      if (addrPh) begin
        lastAddr = shIn;
        active = (shIn[7:1] == DEV_ADDR);
        isRead = shIn[0];
        slvLow = active;
      end else if (active && !isRead) begin
        wrLog[wrCnt[2:0]] = shIn;
        slvLow = (nackAt != wrCnt);
        wrCnt++;
      end else slvLow = 1'b0;
    end else if (bitCnt == 9) begin
      bitCnt = 0;
      slvLow = 1'b0;
      if (addrPh) begin
        addrPh = 1'b0;
        if (active && isRead) begin rdByte = rdData[rdIdx[2:0]]; slvLow = !rdByte[7]; end
      end else if (active && isRead) begin
        mAck[mAckCnt[2:0]] = ackSeen; mAckCnt++; rdIdx++;
        if (!ackSeen) begin rdByte = rdData[rdIdx[2:0]]; slvLow = !rdByte[7]; end
        else active = 1'b0;
      end
    end else if (bitCnt >= 1 && bitCnt <= 7 && active && isRead && !addrPh) begin
      slvLow = !rdByte[7-bitCnt];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    startCnt = 0; stopCnt = 0; wrCnt = 0; mAckCnt = 0; rdIdx = 0; nackAt = -1;
    @(negedge clk); txIdx = 0; rxCnt = 0;
  endtask

  task automatic launch(input logic rd, input logic stp, input logic run,
                        input logic [7:0] n, input logic [6:0] adr);
    @(negedge clk);
    addrWord = 32'(adr) << 10;
    launchWord = {run, 13'd0, stp, rd, 8'd0, n};
    launchWr = 1'b1;
    @(negedge clk);
    launchWr = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && status[17]; i++) @(negedge clk);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && !status[0]; i++) @(negedge clk);
  endtask

  task automatic readStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sclOe", 32'(sclOe), 0);
    check("R1 sdaOe", 32'(sdaOe), 0);
    check("R1 status", status, 0);
  endtask

  task automatic t_write();
    clearModel();
    txBuf[0] = 8'hA5; txBuf[1] = 8'h3C; txBuf[2] = 8'h81;
    launch(1'b0, 1'b1, 1'b1, 8'd3, DEV_ADDR);
    waitIdle();
    check("R2 address byte", 32'(lastAddr), 32'({DEV_ADDR, 1'b0}));
    check("R3 byte count", 32'(wrCnt), 3);
    check("R3 byte0", 32'(wrLog[0]), 32'hA5);
    check("R3 byte1", 32'(wrLog[1]), 32'h3C);
    check("R3 byte2", 32'(wrLog[2]), 32'h81);
    check("R3 takes", 32'(txIdx), 3);
    check("R5 stop seen", 32'(stopCnt), 1);
    check("R5 status done idle", status, 32'h1);
    check("R5 lines released", 32'({sclOe, sdaOe}), 0);
  endtask

  task automatic t_doneClear();
    check("R7 done sticky", 32'(status[0]), 1);
    readStatus();
    check("R7 done cleared", status, 0);
  endtask

  task automatic t_read();
    clearModel();
    rdData[0] = 8'h5E; rdData[1] = 8'hC3;
    launch(1'b1, 1'b1, 1'b1, 8'd2, DEV_ADDR);
    waitIdle();
    check("R2 read address byte", 32'(lastAddr), 32'({DEV_ADDR, 1'b1}));
    check("R4 rx count", 32'(rxCnt), 2);
    check("R4 rx0", 32'(rxLog[0]), 32'h5E);
    check("R4 rx1", 32'(rxLog[1]), 32'hC3);
    check("R4 ack first", 32'(mAck[0]), 0);
    check("R4 nack last", 32'(mAck[1]), 1);
    check("R5 read stop", 32'(stopCnt), 1);
    readStatus();
  endtask

  task automatic t_restart();
    clearModel();
    txBuf[0] = 8'h17; rdData[0] = 8'h99;
    launch(1'b0, 1'b0, 1'b1, 8'd1, DEV_ADDR);
    waitDone();
    repeat (40) @(negedge clk);
    check("R6 busy held", 32'(status[17]), 1);
    check("R6 scl held low", 32'(sclOe), 1);
    check("R6 no stop", 32'(stopCnt), 0);
    readStatus();
    launch(1'b1, 1'b1, 1'b1, 8'd1, DEV_ADDR);
    waitIdle();
    check("R6 repeated start", 32'(startCnt), 2);
    check("R6 stop count", 32'(stopCnt), 1);
    check("R6 read after restart", 32'(rxLog[0]), 32'h99);
    check("R6 written byte", 32'(wrLog[0]), 32'h17);
    readStatus();
  endtask

  task automatic t_addrNack();
    clearModel();
    launch(1'b0, 1'b1, 1'b1, 8'd2, 7'h33);
    waitIdle();
    check("R8 status no-device", status, 32'h8);
    check("R8 stop", 32'(stopCnt), 1);
    check("R8 no take", 32'(txIdx), 0);
  endtask

  task automatic t_dataNack();
    clearModel();
    nackAt = 1;
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    launch(1'b0, 1'b1, 1'b1, 8'd3, DEV_ADDR);
    waitIdle();
    check("R9 status no-ack", status, 32'h4);
    check("R9 bytes sent", 32'(wrCnt), 2);
    check("R9 takes", 32'(txIdx), 2);
    check("R9 stop", 32'(stopCnt), 1);
  endtask

  task automatic t_ignore();
    clearModel();
    launch(1'b0, 1'b1, 1'b0, 8'd1, DEV_ADDR);
    repeat (10) @(negedge clk);
    check("R2 run clear ignored", 32'(status[17]), 0);
    txBuf[0] = 8'h6B; txBuf[1] = 8'h4D;
    launch(1'b0, 1'b1, 1'b1, 8'd2, DEV_ADDR);
    repeat (60) @(negedge clk);
    launch(1'b1, 1'b1, 1'b1, 8'd1, 7'h11);
    waitIdle();
    check("R11 bytes", 32'(wrCnt), 2);
    check("R11 byte1", 32'(wrLog[1]), 32'h4D);
    check("R11 no rx", 32'(rxCnt), 0);
    check("R11 status", status, 32'h1);
    readStatus();
  endtask

  task automatic t_zero();
    clearModel();
    launch(1'b0, 1'b1, 1'b1, 8'd0, DEV_ADDR);
    waitIdle();
    check("R2 zero count done", status, 32'h1);
    check("R2 zero count no take", 32'(txIdx), 0);
    check("R2 zero count stop", 32'(stopCnt), 1);
    readStatus();
  endtask

  task automatic t_arb();
    clearModel();
    otherLow = 1'b1;
    launch(1'b0, 1'b1, 1'b1, 8'd1, DEV_ADDR);
    waitIdle();
    check("R10 abort status", status, 32'h2);
    check("R10 lines released", 32'({sclOe, sdaOe}), 0);
    check("R10 no stop", 32'(stopCnt), 0);
    otherLow = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_doneClear();
    t_read();
    t_restart();
    t_addrNack();
    t_dataNack();
    t_ignore();
    t_zero();
    t_arb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule